// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block lets a synchronous host issue single-byte reads and writes to an external asynchronous static RAM with a 20-bit address and an 8-bit shared data bus. The host offers a request (address, write byte, write flag) on a valid/ready port. The controller then plays out the memory's strobe sequence: two chip selects of opposite polarity, an active-low output enable, an active-low write enable, and a tri-state data bus. Each read returns its byte through a one-cycle read-data-valid pulse.

Every strobe phase is a whole number of clock cycles. That number is worked out at elaboration from nanosecond limits and a clock-period parameter: the limit divided by the period, rounded up, and never less than one cycle. A read holds output enable low long enough to cover address access, chip-select access, output-enable access and the minimum cycle time. The read is then followed by a turnaround gap, with every strobe inactive, that outlasts the memory's release time after output enable or chip select is removed.

A write runs in three phases. First an address setup phase. Then a write-enable pulse long enough for the pulse width, the address-to-end-of-write time and the data setup time. Finally one hold cycle in which write enable is high and the byte is still driven. Output enable stays high for the whole write, so the memory never drives the bus while the controller does.

Top module: `asram_ctl`

## Requirements
- R1: While the synchronous reset `rst` is high, and on the first cycle after it is released, the memory is deselected (`mem_cs1_n`=1, `mem_cs2`=0), `mem_oe_n`=1, `mem_we_n`=1, the data bus is released, `req_ready`=1 and `rd_valid`=0. This holds even when reset lands in the middle of a write pulse.
- R2: For a read, `mem_oe_n` is low for exactly RD = max over {45, 45, 30, 45} ns of ceil(t/CLK_PERIOD_NS) cycles (9 at 5 ns). The byte is sampled from the bus on the clock edge that ends that phase. `rd_valid` is then high for exactly one cycle, carrying the byte stored at the requested address.
- R3: For a write, `mem_we_n` is low for exactly WP = max over {45, 25, 45, 45} ns of ceil(t/CLK_PERIOD_NS) cycles (9 at 5 ns). `mem_oe_n` stays high for the whole write, and `rd_valid` stays low.
- R4: During an access the memory is selected (`mem_cs1_n`=0 and `mem_cs2`=1) and `mem_addr` holds the requested address without change. Write enable falls only after AS = max(1, ceil(0/CLK_PERIOD_NS)) = 1 setup cycle with the chip selected.
- R5: After the output-enable phase of a read ends, TURN = ceil(20/CLK_PERIOD_NS) cycles (4 at 5 ns) follow with the memory deselected and both enables high, before any next access can start.
- R6: `req_ready` is low from the cycle after a request is accepted until the access ends. A request presented while `req_ready` is low causes no strobe and does not change memory contents.
- R7: The controller drives `mem_dq` with the write byte only while `mem_we_n` is low and during the one hold cycle after it rises. At all other times the bus is released.
- R8: Between accesses (whenever `req_ready` is high) the memory is deselected and both enables are high.
- R9: The time from acceptance to the return of `req_ready` is RD+TURN cycles for a read (13 at 5 ns) and AS+WP+1 cycles for a write (11 at 5 ns).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all logic changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Host offers a request |
| req_ready | output | 1 | Controller can accept a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (20) | Byte address of the request |
| req_wdata | input | DATA_W (8) | Byte to write |
| rd_valid | output | 1 | One-cycle pulse: `rd_data` holds a read result |
| rd_data | output | DATA_W (8) | Byte returned by the last read |
| mem_addr | output | ADDR_W (20) | Address to the memory |
| mem_cs1_n | output | 1 | Chip select, active low |
| mem_cs2 | output | 1 | Chip select, active high |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_dq | inout | DATA_W (8) | Bidirectional data bus |

## Verification
The hardest case to reach from the ports is a read whose capture edge is off by one cycle. A real asynchronous memory would still return the right byte after any sampling edge that is merely late. To expose this, the bench's memory model returns the bitwise inverse of the stored byte until output enable has been low for the full access count, so an early capture reads wrong data. A second hard case is a request that changes while the controller is busy. One read in every two keeps a conflicting write request valid through the whole busy period. A final readback of every location then shows that the stray request never reached the memory. A reset is also forced in the middle of a write pulse.

// File: rtl/asram_ctl_pkg.sv
package asram_ctl_pkg;

   // Sequencer states; each non-idle state is one timed strobe phase
   typedef enum logic [2:0] {
      ST_IDLE     = 3'd0,
      ST_RD_ACC   = 3'd1,
      ST_RD_TURN  = 3'd2,
      ST_WR_SETUP = 3'd3,
      ST_WR_PULSE = 3'd4,
      ST_WR_HOLD  = 3'd5
   } ctl_state_e;

   // Strobe set in active-high form, registered into pin polarity later
   typedef struct packed {
      logic sel;
      logic rd_en;
      logic wr_en;
      logic drive;
   } strobe_t;

   localparam strobe_t STROBE_OFF = '{sel: 1'b0, rd_en: 1'b0, wr_en: 1'b0, drive: 1'b0};

   // Whole cycles covering a nanosecond limit, never fewer than one
   function automatic int unsigned ns_to_cycles(input int unsigned ns, input int unsigned period);
      int unsigned c;
      c = (ns + period - 1) / period;
      return (c < 1) ? 1 : c;
   endfunction

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

   function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                        input int unsigned c, input int unsigned d);
      return max2(max2(a, b), max2(c, d));
   endfunction

   // Bits needed to count down from n-1 to zero
   function automatic int unsigned count_width(input int unsigned n);
      int unsigned w;
      w = 1;
      while ((1 << w) < n) w++;
      return w;
   endfunction

endpackage

// File: rtl/asram_phase_timer.sv
module asram_phase_timer #(
   parameter int unsigned CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             last
);

   logic [CNT_W-1:0] cnt_q;

   generate
      if (CNT_W < 1) begin : g_bad_width
         $error("asram_phase_timer: CNT_W must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign last = (cnt_q == '0);

   // R9: a freshly loaded non-zero count is not seen as finished
   load_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (load && (load_val != '0)) |=> !last);

endmodule

// File: rtl/asram_seq.sv
module asram_seq
   import asram_ctl_pkg::*;
#(
   parameter int unsigned RD_CYC   = 9,
   parameter int unsigned TURN_CYC = 4,
   parameter int unsigned AS_CYC   = 1,
   parameter int unsigned WP_CYC   = 9,
   parameter int unsigned HOLD_CYC = 1,
   parameter int unsigned CNT_W    = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             req_fire,
   input  logic             req_write,
   input  logic             phase_last,
   output logic             idle,
   output logic             tmr_load,
   output logic [CNT_W-1:0] tmr_val,
   output logic             capture,
   output strobe_t          strobe_nxt
);

   ctl_state_e state_q, state_d;

   generate
      if (RD_CYC < 1 || TURN_CYC < 1 || AS_CYC < 1 || WP_CYC < 1 || HOLD_CYC < 1) begin : g_bad_phase
         $error("asram_seq: every phase needs at least one cycle");
      end
      if ((1 << CNT_W) < RD_CYC || (1 << CNT_W) < WP_CYC || (1 << CNT_W) < TURN_CYC) begin : g_bad_cnt
         $error("asram_seq: CNT_W too narrow for the phase lengths");
      end
   endgenerate

   always_comb begin
      state_d  = state_q;
      tmr_load = 1'b0;
      tmr_val  = '0;
      capture  = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (req_fire) begin
               tmr_load = 1'b1;
               if (req_write) begin
                  state_d = ST_WR_SETUP;
                  tmr_val = CNT_W'(AS_CYC - 1);
               end else begin
                  state_d = ST_RD_ACC;
                  tmr_val = CNT_W'(RD_CYC - 1);
               end
            end
         end
         ST_RD_ACC: begin
            if (phase_last) begin
               capture  = 1'b1;
               tmr_load = 1'b1;
               tmr_val  = CNT_W'(TURN_CYC - 1);
               state_d  = ST_RD_TURN;
            end
         end
         ST_RD_TURN: begin
            if (phase_last) state_d = ST_IDLE;
         end
         ST_WR_SETUP: begin
            if (phase_last) begin
               tmr_load = 1'b1;
               tmr_val  = CNT_W'(WP_CYC - 1);
               state_d  = ST_WR_PULSE;
            end
         end
         ST_WR_PULSE: begin
            if (phase_last) begin
               tmr_load = 1'b1;
               tmr_val  = CNT_W'(HOLD_CYC - 1);
               state_d  = ST_WR_HOLD;
            end
         end
         ST_WR_HOLD: begin
            if (phase_last) state_d = ST_IDLE;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   // Pin levels for the coming cycle follow the state being entered
   always_comb begin
      strobe_nxt       = STROBE_OFF;
      strobe_nxt.sel   = (state_d == ST_RD_ACC) || (state_d == ST_WR_SETUP) ||
                         (state_d == ST_WR_PULSE) || (state_d == ST_WR_HOLD);
      strobe_nxt.rd_en = (state_d == ST_RD_ACC);
      strobe_nxt.wr_en = (state_d == ST_WR_PULSE);
      strobe_nxt.drive = (state_d == ST_WR_PULSE) || (state_d == ST_WR_HOLD);
   end

   always_ff @(posedge clk) begin
      if (rst) state_q <= ST_IDLE;
      else     state_q <= state_d;
   end

   assign idle = (state_q == ST_IDLE);

   // R5: a read access always moves on to the turnaround gap
   rd_to_turn_chk: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_RD_ACC && phase_last) |=> (state_q == ST_RD_TURN));

   // R3: a write pulse is always followed by the hold cycle
   pulse_to_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_WR_PULSE && phase_last) |=> (state_q == ST_WR_HOLD));

endmodule

// File: rtl/asram_pin_reg.sv
module asram_pin_reg
   import asram_ctl_pkg::*;
#(
   parameter int unsigned ADDR_W = 20,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load_req,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  strobe_t           strobe_nxt,
   input  logic              capture,
   input  logic [DATA_W-1:0] dq_in,
   output logic [ADDR_W-1:0] addr_o,
   output logic              cs1_n_o,
   output logic              cs2_o,
   output logic              oe_n_o,
   output logic              we_n_o,
   output logic              drive_o,
   output logic [DATA_W-1:0] dq_out_o,
   output logic              rd_valid_o,
   output logic [DATA_W-1:0] rd_data_o
);

   strobe_t strobe_q;

   // Request fields are latched once at acceptance and held for the access
   always_ff @(posedge clk) begin
      if (rst) begin
         addr_o   <= '0;
         dq_out_o <= '0;
      end else if (load_req) begin
         addr_o   <= req_addr;
         dq_out_o <= req_wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) strobe_q <= STROBE_OFF;
      else     strobe_q <= strobe_nxt;
   end

   // Both selects come from one flop so they always switch together
   assign cs1_n_o = ~strobe_q.sel;
   assign cs2_o   =  strobe_q.sel;
   assign oe_n_o  = ~strobe_q.rd_en;
   assign we_n_o  = ~strobe_q.wr_en;
   assign drive_o =  strobe_q.drive;

   always_ff @(posedge clk) begin
      if (rst) begin
         rd_valid_o <= 1'b0;
         rd_data_o  <= '0;
      end else begin
         rd_valid_o <= capture;
         if (capture) rd_data_o <= dq_in;
      end
   end

   // R2: read-data-valid never lasts two cycles
   rd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      rd_valid_o |=> !rd_valid_o);

   // R4: address is frozen while the chip stays selected
   addr_stable_chk: assert property (@(posedge clk) disable iff (rst)
      (!cs1_n_o && $past(!cs1_n_o)) |-> $stable(addr_o));

endmodule

// File: rtl/asram_ctl.sv
module asram_ctl
   import asram_ctl_pkg::*;
#(
   parameter int unsigned ADDR_W        = 20,
   parameter int unsigned DATA_W        = 8,
   parameter int unsigned CLK_PERIOD_NS = 5,
   parameter int unsigned T_RC_NS       = 45,
   parameter int unsigned T_AA_NS       = 45,
   parameter int unsigned T_CO_NS       = 45,
   parameter int unsigned T_OE_NS       = 30,
   parameter int unsigned T_OHZ_NS      = 20,
   parameter int unsigned T_HZ_NS       = 20,
   parameter int unsigned T_WC_NS       = 45,
   parameter int unsigned T_AS_NS       = 0,
   parameter int unsigned T_AW_NS       = 45,
   parameter int unsigned T_WP_NS       = 45,
   parameter int unsigned T_DW_NS       = 25,
   parameter int unsigned T_DH_NS       = 0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_cs1_n,
   output logic              mem_cs2,
   output logic              mem_oe_n,
   output logic              mem_we_n,
   inout  wire  [DATA_W-1:0] mem_dq
);

   localparam int unsigned P        = (CLK_PERIOD_NS == 0) ? 1 : CLK_PERIOD_NS;
   localparam int unsigned RD_CYC   = max4(ns_to_cycles(T_RC_NS, P), ns_to_cycles(T_AA_NS, P),
                                           ns_to_cycles(T_CO_NS, P), ns_to_cycles(T_OE_NS, P));
   localparam int unsigned TURN_CYC = max2(ns_to_cycles(T_OHZ_NS, P), ns_to_cycles(T_HZ_NS, P));
   localparam int unsigned AS_CYC   = ns_to_cycles(T_AS_NS, P);
   localparam int unsigned WP_CYC   = max4(ns_to_cycles(T_WP_NS, P), ns_to_cycles(T_DW_NS, P),
                                           ns_to_cycles(T_AW_NS, P), ns_to_cycles(T_WC_NS, P));
   localparam int unsigned HOLD_CYC = ns_to_cycles(T_DH_NS, P);
   localparam int unsigned MAX_CYC  = max4(RD_CYC, TURN_CYC, WP_CYC, max2(AS_CYC, HOLD_CYC));
   localparam int unsigned CNT_W    = count_width(MAX_CYC);

   generate
      if (CLK_PERIOD_NS == 0) begin : g_bad_period
         $error("asram_ctl: CLK_PERIOD_NS must be non-zero");
      end
      if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_bus
         $error("asram_ctl: bus widths must be at least 1");
      end
      if ((AS_CYC + WP_CYC + HOLD_CYC) * P < T_WC_NS) begin : g_bad_wc
         $error("asram_ctl: write phases shorter than the write cycle time");
      end
   endgenerate

   logic             req_fire;
   logic             seq_idle;
   logic             tmr_load;
   logic [CNT_W-1:0] tmr_val;
   logic             phase_last;
   logic             capture;
   strobe_t          strobe_nxt;
   logic             dq_drive;
   logic [DATA_W-1:0] dq_out;

   assign req_ready = seq_idle;
   assign req_fire  = req_valid && seq_idle;

   asram_phase_timer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst      (rst),
      .load     (tmr_load),
      .load_val (tmr_val),
      .last     (phase_last)
   );

   asram_seq #(
      .RD_CYC   (RD_CYC),
      .TURN_CYC (TURN_CYC),
      .AS_CYC   (AS_CYC),
      .WP_CYC   (WP_CYC),
      .HOLD_CYC (HOLD_CYC),
      .CNT_W    (CNT_W)
   ) u_seq (
      .clk        (clk),
      .rst        (rst),
      .req_fire   (req_fire),
      .req_write  (req_write),
      .phase_last (phase_last),
      .idle       (seq_idle),
      .tmr_load   (tmr_load),
      .tmr_val    (tmr_val),
      .capture    (capture),
      .strobe_nxt (strobe_nxt)
   );

   asram_pin_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
      .clk        (clk),
      .rst        (rst),
      .load_req   (req_fire),
      .req_addr   (req_addr),
      .req_wdata  (req_wdata),
      .strobe_nxt (strobe_nxt),
      .capture    (capture),
      .dq_in      (mem_dq),
      .addr_o     (mem_addr),
      .cs1_n_o    (mem_cs1_n),
      .cs2_o      (mem_cs2),
      .oe_n_o     (mem_oe_n),
      .we_n_o     (mem_we_n),
      .drive_o    (dq_drive),
      .dq_out_o   (dq_out),
      .rd_valid_o (rd_valid),
      .rd_data_o  (rd_data)
   );

   assign mem_dq = dq_drive ? dq_out : {DATA_W{1'bz}};

   // Cycles spent with write enable low, for the pulse width check
   logic [CNT_W:0] we_low_cnt;
   always_ff @(posedge clk) begin
      if (rst || mem_we_n) we_low_cnt <= '0;
      else                 we_low_cnt <= we_low_cnt + 1'b1;
   end

   // R1
   reset_idle_chk: assert property (@(posedge clk)
      rst |=> (mem_cs1_n && !mem_cs2 && mem_oe_n && mem_we_n && !dq_drive && !rd_valid));

   // R3
   we_width_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(mem_we_n) |-> (we_low_cnt == (CNT_W+1)'(WP_CYC)));

   // R3
   oe_we_excl_chk: assert property (@(posedge clk) disable iff (rst)
      !(!mem_oe_n && !mem_we_n));

   // R7
   drive_window_chk: assert property (@(posedge clk) disable iff (rst)
      dq_drive |-> (mem_oe_n && !mem_cs1_n));

   // R7
   drive_in_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      !mem_we_n |-> dq_drive);

   // R5
   turn_deselect_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(mem_oe_n) |-> (mem_cs1_n && !mem_cs2 && mem_we_n));

   // R6
   busy_on_return_chk: assert property (@(posedge clk) disable iff (rst)
      rd_valid |-> !req_ready);

   // R8
   idle_deselect_chk: assert property (@(posedge clk) disable iff (rst)
      req_ready |-> (mem_cs1_n && !mem_cs2 && mem_oe_n && mem_we_n));

endmodule

// File: tb/asram_ctl_test.sv
`timescale 1ns/1ps
module asram_ctl_test;

   localparam int AW = 8;
   localparam int DW = 8;
   localparam int PER = 5;

   function automatic int cyc(input int ns);
      int c;
      c = (ns + PER - 1) / PER;
      return (c < 1) ? 1 : c;
   endfunction

   localparam int RD_EXP   = cyc(45);
   localparam int TURN_EXP = cyc(20);
   localparam int AS_EXP   = cyc(0);
   localparam int WP_EXP   = cyc(45);

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          req_valid = 1'b0;
   logic          req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic          req_ready, rd_valid;
   logic [DW-1:0] rd_data;
   logic [AW-1:0] mem_addr;
   logic          mem_cs1_n, mem_cs2, mem_oe_n, mem_we_n;
   wire  [DW-1:0] dq_bus;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   asram_ctl #(.ADDR_W(AW), .DATA_W(DW), .CLK_PERIOD_NS(PER)) uut (
      .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .rd_valid(rd_valid), .rd_data(rd_data), .mem_addr(mem_addr),
      .mem_cs1_n(mem_cs1_n), .mem_cs2(mem_cs2), .mem_oe_n(mem_oe_n),
      .mem_we_n(mem_we_n), .mem_dq(dq_bus)
   );

   // Memory model: wrong (inverted) data until output enable has been low long enough
   logic [DW-1:0] mdl_mem [0:(1<<AW)-1];
   int            oe_run = 0;
   logic          mdl_en;
   logic [DW-1:0] mdl_data;

   always @(negedge clk) begin
      if (mem_oe_n || mem_cs1_n || !mem_cs2) oe_run <= 0;
      else                                    oe_run <= oe_run + 1;
   end

   assign mdl_en   = !mem_cs1_n && mem_cs2 && !mem_oe_n && mem_we_n;
   assign mdl_data = (oe_run >= RD_EXP) ? mdl_mem[mem_addr] : ~mdl_mem[mem_addr];
   assign dq_bus   = mdl_en ? mdl_data : {DW{1'bz}};

   always @(posedge mem_we_n) begin
      if (!mem_cs1_n && mem_cs2) mdl_mem[mem_addr] = dq_bus;
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] pat1(input int a);
      return DW'((a * 37 + 11) & 8'hFF);
   endfunction

   function automatic logic [DW-1:0] pat2(input int a);
      return DW'(a ^ 8'hC3);
   endfunction

   task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
      int busy = 0, wlow = 0, setup = 0, hold = 0, bad = 0, dbad = 0;
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
      @(negedge clk);
      req_valid = 1'b0;
      while (!req_ready) begin
         busy++;
         if (mem_cs1_n || !mem_cs2 || mem_addr != a || !mem_oe_n || rd_valid) bad++;
         if (!mem_we_n) begin
            wlow++;
            if (dq_bus != d) dbad++;
         end else if (wlow == 0) begin
            setup++;
         end else begin
            hold++;
            if (dq_bus != d) dbad++;
         end
         @(negedge clk);
      end
      chk(wlow == WP_EXP, "R3 write enable low cycles", wlow, WP_EXP);
      chk(setup == AS_EXP, "R4 setup cycles before write enable", setup, AS_EXP);
      chk(bad == 0, "R4 select/address/oe during write", bad, 0);
      chk(hold == 1 && dbad == 0, "R7 data driven in pulse and hold", dbad + 10 * hold, 10);
      chk(busy == AS_EXP + WP_EXP + 1, "R9 write busy cycles", busy, AS_EXP + WP_EXP + 1);
      chk(mem_cs1_n && !mem_cs2 && mem_oe_n && mem_we_n, "R8 idle strobes after write",
          {mem_cs1_n, mem_cs2, mem_oe_n, mem_we_n}, 4'b1011);
   endtask

   task automatic do_read(input logic [AW-1:0] a, input logic [DW-1:0] exp, input bit noise);
      int busy = 0, olow = 0, turn = 0, rv = 0, bad = 0;
      logic [DW-1:0] got = '0;
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_wdata = 8'h00;
      @(negedge clk);
      if (noise) begin
         req_valid = 1'b1; req_write = 1'b1; req_addr = a ^ 8'h80; req_wdata = 8'hFF;
      end else begin
         req_valid = 1'b0;
      end
      while (!req_ready) begin
         busy++;
         if (!mem_we_n) bad++;
         if (!mem_oe_n) begin
            olow++;
            if (mem_cs1_n || !mem_cs2 || mem_addr != a) bad++;
         end else begin
            turn++;
            if (!mem_cs1_n || mem_cs2) bad++;
         end
         if (rd_valid) begin
            rv++;
            got = rd_data;
         end
         @(negedge clk);
      end
      req_valid = 1'b0;
      chk(olow == RD_EXP, "R2 output enable low cycles", olow, RD_EXP);
      chk(rv == 1, "R2 single read-valid pulse", rv, 1);
      chk(got == exp, "R2 read data", int'(got), int'(exp));
      chk(turn == TURN_EXP, "R5 turnaround cycles", turn, TURN_EXP);
      chk(bad == 0, "R6 no stray strobe while busy", bad, 0);
      chk(busy == RD_EXP + TURN_EXP, "R9 read busy cycles", busy, RD_EXP + TURN_EXP);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: state during reset
      chk(mem_cs1_n && !mem_cs2 && mem_oe_n && mem_we_n && req_ready && !rd_valid,
          "R1 reset levels", {mem_cs1_n, mem_cs2, mem_oe_n, mem_we_n, req_ready, rd_valid}, 6'b101110);
      rst = 1'b0;
      @(negedge clk);
      chk(mem_cs1_n && !mem_cs2 && req_ready, "R1 after release", {mem_cs1_n, mem_cs2, req_ready}, 3'b101);

      // Full sweep: write every location, then read all back-to-back
      for (int a = 0; a < (1 << AW); a++) do_write(AW'(a), pat1(a));
      for (int a = 0; a < (1 << AW); a++) do_read(AW'(a), pat1(a), 1'b0);

      // Write-then-read alternation; odd reads hold a conflicting request (R6)
      for (int a = 0; a < (1 << AW); a++) begin
         do_write(AW'(a), pat2(a));
         do_read(AW'(a), pat2(a), a[0]);
      end
      for (int a = 0; a < (1 << AW); a++) do_read(AW'(a), pat2(a), 1'b0);

      // R1: reset in the middle of the write pulse
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_addr = 8'h03; req_wdata = 8'h99;
      @(negedge clk);
      req_valid = 1'b0;
      repeat (4) @(negedge clk);
      chk(!mem_we_n, "R1 precondition write pulse active", mem_we_n, 0);
      rst = 1'b1;
      @(negedge clk);
      chk(mem_cs1_n && !mem_cs2 && mem_oe_n && mem_we_n && req_ready,
          "R1 reset during write", {mem_cs1_n, mem_cs2, mem_oe_n, mem_we_n, req_ready}, 5'b10111);
      @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      do_write(8'h03, 8'h5A);
      do_read(8'h03, 8'h5A, 1'b0);
      do_read(8'h83, pat2(8'h83), 1'b0);

      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule